// File: doc/BRIEF.md
# Dual-Direction UART Baud Timer

A 16-bit up-counting timer with a reload register. Its overflow can serve as the bit-clock source for a UART. When either direction-select input is high, the timer enters baud mode. In baud mode it always reloads on overflow. Internal counting then advances once every two system clocks, whatever prescaler is chosen. Each overflow feeds a divide-by-16 stage that produces a one-cycle bit-clock enable. The receive and transmit directions pick their source independently: either this timer's overflow, or an overflow strobe from a second timer. In baud mode an overflow never sets the overflow flag.

Outside baud mode the block acts as a plain auto-reload timer. Each overflow sets a sticky overflow flag. The counting rate is one count per clock or one per twelve clocks. An external count pin can replace the internal timebase in any mode. A falling edge on a separate trigger pin sets an external flag, which gives an extra interrupt source that stays live in baud mode. Bus strobes write the reload and counter registers one byte at a time. Clear strobes reset the flags.

Top module: `brg_timer`

## Requirements
- R1: After reset the counter and reload registers are 0, and both flags, the interrupt request and both bit enables are 0.
- R2: While `run_en` is 0 the counter holds its value.
- R3: Outside baud mode, with internal counting, the counter advances by 1 every clock when `slow_sel` is 0 and by 1 every 12 clocks when `slow_sel` is 1.
- R4: Baud mode is active when `rx_sel` or `tx_sel` is 1. In baud mode internal counting advances by 1 every 2 clocks, and `slow_sel` has no effect.
- R5: With `cnt_src_ext` at 1 the counter advances once per falling edge of `ext_cnt_pin`, seen through a two-flop synchronizer. The system clock then does not drive counting.
- R6: A count from 16'hFFFF loads the reload value into the counter. The one exception is outside baud mode with `cap_sel` at 1: there the counter wraps to 0. In baud mode it reloads whatever `cap_sel` says.
- R7: An overflow outside baud mode sets `ovf_flag`. An overflow in baud mode never sets it.
- R8: The receive enable is fed by this timer's overflow when `rx_sel` is 1, or by `other_ovf` when `rx_sel` is 0. The transmit enable is chosen the same way by `tx_sel`. Each enable is a one-cycle pulse on every 16th source event. For internal counting the period is 32 × (65536 − reload) clocks.
- R9: Outside baud mode both enables stay 0. Both divide-by-16 stages restart from zero, so after re-entry the first pulse comes 16 source events later.
- R10: With `trig_en` at 1 a falling edge of `ext_trig_pin` sets `ext_flag`, in baud mode as well. With `trig_en` at 0 the edge is ignored.
- R11: Both flags stay set until their clear strobe is pulsed. `irq` is high exactly when `irq_en` is 1 and at least one flag is set.
- R12: `wr_rld_lo`/`wr_rld_hi` and `wr_cnt_lo`/`wr_cnt_hi` load `wr_data` into bits 7:0 or 15:8 of the reload or counter register. A counter write takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cnt_pin | input | 1 | External count input (falling edges) |
| ext_trig_pin | input | 1 | External trigger input (falling edges) |
| run_en | input | 1 | Counting enable |
| rx_sel | input | 1 | Receive clock from this timer (1) or other timer (0) |
| tx_sel | input | 1 | Transmit clock from this timer (1) or other timer (0) |
| cnt_src_ext | input | 1 | Count external pin edges instead of clock |
| cap_sel | input | 1 | Outside baud mode: wrap to 0 instead of reloading |
| slow_sel | input | 1 | Outside baud mode: divide-by-12 timebase |
| trig_en | input | 1 | Enable trigger-pin flag |
| irq_en | input | 1 | Interrupt enable |
| other_ovf | input | 1 | Overflow strobe of the second timer |
| wr_data | input | 8 | Bus write data byte |
| wr_rld_lo | input | 1 | Write reload bits 7:0 |
| wr_rld_hi | input | 1 | Write reload bits 15:8 |
| wr_cnt_lo | input | 1 | Write counter bits 7:0 |
| wr_cnt_hi | input | 1 | Write counter bits 15:8 |
| clr_ovf_flag | input | 1 | Clear overflow flag |
| clr_ext_flag | input | 1 | Clear external flag |
| cnt_val | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external trigger flag |
| irq | output | 1 | Interrupt request |
| rx_bit_en | output | 1 | Receive bit-clock enable pulse |
| tx_bit_en | output | 1 | Transmit bit-clock enable pulse |

## Verification
The properties assume that the mode inputs and the bus strobes are synchronous to `clk` and change only between edges. They also assume that `other_ovf` is a single-cycle strobe. The bench drives every input just after the falling clock edge. It stops counting before it writes a 16-bit value in two byte strobes, and it pulses `other_ovf` for one cycle in every K. Bit-clock periods are measured from pulse to pulse, so the result does not depend on the divide-by-16 phase or on synchronizer latency.

// File: rtl/brg_pkg.sv
package brg_pkg;
    localparam int DEF_CNT_W       = 16;
    localparam int DEF_BIT_DIV     = 16;
    localparam int DEF_SLOW_DIV    = 12;
    localparam int DEF_SYNC_STAGES = 2;
    localparam int NUM_DIRS        = 2;

    typedef enum logic [0:0] {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;
endpackage

// File: rtl/brg_sync_fall.sv
module brg_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[SH_W-2:0], pin_i};
        fall_o = sh_q[SH_W-1] & ~sh_q[SH_W-2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/brg_bitdiv.sv
module brg_bitdiv #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic pulse_i,
    output logic pulse_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         out;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (pulse_i) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.out = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.out;
endmodule

// File: rtl/brg_timer.sv
module brg_timer
    import brg_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int BIT_DIV     = DEF_BIT_DIV,
    parameter int SLOW_DIV    = DEF_SLOW_DIV,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_cnt_pin,
    input  logic               ext_trig_pin,
    input  logic               run_en,
    input  logic               rx_sel,
    input  logic               tx_sel,
    input  logic               cnt_src_ext,
    input  logic               cap_sel,
    input  logic               slow_sel,
    input  logic               trig_en,
    input  logic               irq_en,
    input  logic               other_ovf,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               wr_rld_lo,
    input  logic               wr_rld_hi,
    input  logic               wr_cnt_lo,
    input  logic               wr_cnt_hi,
    input  logic               clr_ovf_flag,
    input  logic               clr_ext_flag,
    output logic [CNT_W-1:0]   cnt_val,
    output logic               ovf_flag,
    output logic               ext_flag,
    output logic               irq,
    output logic               rx_bit_en,
    output logic               tx_bit_en
);
    localparam int HALF_W = CNT_W / 2;
    localparam int SLOW_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
    localparam logic [SLOW_W-1:0] SLOW_LAST = SLOW_W'(SLOW_DIV - 1);
    localparam logic [CNT_W-1:0]  CNT_TOP   = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rld;
        logic              half;
        logic [SLOW_W-1:0] slow;
        logic              ovf_flag;
        logic              ext_flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    logic cnt_fall, trig_fall;
    logic baud_mode, tick, ovf, cnt_wr;
    logic [NUM_DIRS-1:0] dir_sel, dir_src, dir_pulse;

    brg_sync_fall #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_cnt_pin), .fall_o(cnt_fall)
    );

    brg_sync_fall #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_trig_pin), .fall_o(trig_fall)
    );

    always_comb begin
        baud_mode = rx_sel | tx_sel;
        cnt_wr    = wr_cnt_lo | wr_cnt_hi;

        if (cnt_src_ext)      tick = run_en & cnt_fall;
        else if (baud_mode)   tick = run_en & st_q.half;
        else if (slow_sel)    tick = run_en & (st_q.slow == SLOW_LAST);
        else                  tick = run_en;

        ovf = tick & (st_q.cnt == CNT_TOP) & ~cnt_wr;

        st_d = st_q;

        // half-rate phase for baud mode
        st_d.half = (run_en && baud_mode && !cnt_src_ext) ? ~st_q.half : 1'b0;

        // divide-by-SLOW_DIV phase for the slow timebase
        if (run_en && !baud_mode && !cnt_src_ext && slow_sel)
            st_d.slow = (st_q.slow == SLOW_LAST) ? '0 : st_q.slow + 1'b1;
        else
            st_d.slow = '0;

        if (wr_rld_lo) st_d.rld[HALF_W-1:0]     = wr_data;
        if (wr_rld_hi) st_d.rld[CNT_W-1:HALF_W] = wr_data;

        if (cnt_wr) begin
            if (wr_cnt_lo) st_d.cnt[HALF_W-1:0]     = wr_data;
            if (wr_cnt_hi) st_d.cnt[CNT_W-1:HALF_W] = wr_data;
        end else if (tick) begin
            if (ovf) st_d.cnt = (baud_mode || !cap_sel) ? st_q.rld : '0;
            else     st_d.cnt = st_q.cnt + 1'b1;
        end

        if (ovf && !baud_mode)  st_d.ovf_flag = 1'b1;
        else if (clr_ovf_flag)  st_d.ovf_flag = 1'b0;

        if (trig_fall && trig_en) st_d.ext_flag = 1'b1;
        else if (clr_ext_flag)    st_d.ext_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_sel[DIR_RX] = rx_sel;
    assign dir_sel[DIR_TX] = tx_sel;

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        assign dir_src[g] = dir_sel[g] ? ovf : other_ovf;
        brg_bitdiv #(.DIV(BIT_DIV)) u_div (
            .clk(clk), .rst_n(rst_n), .clr_i(~baud_mode),
            .pulse_i(dir_src[g]), .pulse_o(dir_pulse[g])
        );
    end

    assign rx_bit_en = dir_pulse[DIR_RX];
    assign tx_bit_en = dir_pulse[DIR_TX];
    assign cnt_val   = st_q.cnt;
    assign ovf_flag  = st_q.ovf_flag;
    assign ext_flag  = st_q.ext_flag;
    assign irq       = irq_en & (st_q.ovf_flag | st_q.ext_flag);
endmodule

// File: rtl/brg_timer_chk.sv
module brg_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             rx_sel,
    input logic             tx_sel,
    input logic             trig_en,
    input logic             wr_cnt_lo,
    input logic             wr_cnt_hi,
    input logic [CNT_W-1:0] cnt_val,
    input logic             ovf_flag,
    input logic             ext_flag,
    input logic             rx_bit_en,
    input logic             tx_bit_en
);
    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_val));

    // R7
    no_flag_in_baud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sel || tx_sel) |=> !$rose(ovf_flag));

    // R9
    quiet_outside_baud_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_sel || tx_sel) |=> (!rx_bit_en && !tx_bit_en));

    // R8
    rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_en |=> !rx_bit_en);

    // R8
    tx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_en |=> !tx_bit_en);

    // R10
    trig_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_flag) |-> $past(trig_en));
endmodule

bind brg_timer brg_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rx_sel(rx_sel),
    .tx_sel(tx_sel), .trig_en(trig_en), .wr_cnt_lo(wr_cnt_lo),
    .wr_cnt_hi(wr_cnt_hi), .cnt_val(cnt_val), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en)
);

// File: tb/brg_timer_tb.sv
module brg_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_cnt_pin = 1'b1, ext_trig_pin = 1'b1;
    logic run_en = 0, rx_sel = 0, tx_sel = 0, cnt_src_ext = 0, cap_sel = 0;
    logic slow_sel = 0, trig_en = 0, irq_en = 0, other_ovf = 0;
    logic [7:0] wr_data = '0;
    logic wr_rld_lo = 0, wr_rld_hi = 0, wr_cnt_lo = 0, wr_cnt_hi = 0;
    logic clr_ovf_flag = 0, clr_ext_flag = 0;
    logic [15:0] cnt_val;
    logic ovf_flag, ext_flag, irq, rx_bit_en, tx_bit_en;

    int n_tests = 0, n_fail = 0;
    int ext_p = 0, oth_k = 0, ext_ph = 0, oth_ph = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    brg_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ext_cnt_pin(ext_cnt_pin), .ext_trig_pin(ext_trig_pin),
        .run_en(run_en), .rx_sel(rx_sel), .tx_sel(tx_sel), .cnt_src_ext(cnt_src_ext),
        .cap_sel(cap_sel), .slow_sel(slow_sel), .trig_en(trig_en), .irq_en(irq_en),
        .other_ovf(other_ovf), .wr_data(wr_data), .wr_rld_lo(wr_rld_lo),
        .wr_rld_hi(wr_rld_hi), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi),
        .clr_ovf_flag(clr_ovf_flag), .clr_ext_flag(clr_ext_flag), .cnt_val(cnt_val),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq),
        .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en)
    );

    // external count pin and second-timer strobe generators
    always @(negedge clk) begin
        if (ext_p > 0) begin
            ext_ph = (ext_ph + 1 >= ext_p) ? 0 : ext_ph + 1;
            ext_cnt_pin = (ext_ph < ext_p / 2) ? 1'b0 : 1'b1;
        end else begin
            ext_cnt_pin = 1'b1;
        end
        if (oth_k > 0) begin
            oth_ph = (oth_ph + 1 >= oth_k) ? 0 : oth_ph + 1;
            other_ovf = (oth_ph == 0);
        end else begin
            other_ovf = 1'b0;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R12 byte writes: kind 0 reload, 1 counter
    task automatic wr16(input bit kind, input logic [15:0] v);
        wr_data = v[7:0];
        if (kind) wr_cnt_lo = 1; else wr_rld_lo = 1;
        step(1);
        wr_cnt_lo = 0; wr_rld_lo = 0;
        wr_data = v[15:8];
        if (kind) wr_cnt_hi = 1; else wr_rld_hi = 1;
        step(1);
        wr_cnt_hi = 0; wr_rld_hi = 0;
    endtask

    task automatic measure(input bit which, output int per);
        int first = -1;
        per = -1;
        for (int t = 0; t < 8000; t++) begin
            step(1);
            if (which ? tx_bit_en : rx_bit_en) begin
                if (first < 0) first = t;
                else begin
                    per = t - first;
                    break;
                end
            end
        end
    endtask

    task automatic rate(output int diff);
        logic [15:0] a;
        run_en = 0;
        wr16(1, 16'h0000);
        run_en = 1;
        step(5);
        a = cnt_val;
        step(120);
        diff = int'(cnt_val - a);
        run_en = 0;
    endtask

    typedef struct packed {
        logic [15:0] rld;
        logic        rx;
        logic        tx;
        logic        cap;
        logic        ext;
        int          ep;
        int          ok;
        int          exp_rx;
        int          exp_tx;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0,  32,  32},
        '{16'hFFFE, 1'b1, 1'b0, 1'b0, 1'b0, 0, 5,  64,  80},
        '{16'hFFFC, 1'b0, 1'b1, 1'b1, 1'b0, 0, 3,  48, 128},
        '{16'hFFFE, 1'b1, 1'b1, 1'b0, 1'b1, 4, 0, 128, 128},
        '{16'hFFF8, 1'b0, 1'b1, 1'b0, 1'b0, 0, 7, 112, 256}
    };

    initial begin
        int per, d;
        step(3);
        // R1 reset state
        check(cnt_val == 0 && !ovf_flag && !ext_flag && !irq && !rx_bit_en && !tx_bit_en,
              "R1", "reset outputs", {cnt_val, ovf_flag, ext_flag, irq, rx_bit_en, tx_bit_en}, 0);
        rst_n = 1;
        step(2);
        check(cnt_val == 0, "R1", "counter after reset", cnt_val, 0);

        // R4 R5 R6 R8: bit-clock periods under several configurations
        for (int i = 0; i < 5; i++) begin
            run_en = 0; rx_sel = 0; tx_sel = 0;
            step(2);
            wr16(0, VECS[i].rld);
            wr16(1, VECS[i].rld);
            ext_p = VECS[i].ep; oth_k = VECS[i].ok;
            cnt_src_ext = VECS[i].ext; cap_sel = VECS[i].cap;
            rx_sel = VECS[i].rx; tx_sel = VECS[i].tx;
            run_en = 1;
            measure(1'b0, per);
            check(per == VECS[i].exp_rx, "R8", $sformatf("vec %0d rx period", i), per, VECS[i].exp_rx);
            measure(1'b1, per);
            check(per == VECS[i].exp_tx, "R8", $sformatf("vec %0d tx period", i), per, VECS[i].exp_tx);
        end
        run_en = 0; rx_sel = 0; tx_sel = 0; ext_p = 0; oth_k = 0;
        cnt_src_ext = 0; cap_sel = 0;
        step(2);

        // R3 timebases
        slow_sel = 0; rate(d);
        check(d == 120, "R3", "divide-by-1 count", d, 120);
        slow_sel = 1; rate(d);
        check(d == 10, "R3", "divide-by-12 count", d, 10);
        // R4 baud mode ignores slow_sel
        rx_sel = 1; rate(d);
        check(d == 60, "R4", "baud half-rate count", d, 60);
        rx_sel = 0; slow_sel = 0;

        // R2 stopped counter holds
        wr16(1, 16'h1234);
        step(20);
        check(cnt_val == 16'h1234, "R2", "hold while stopped", cnt_val, 16'h1234);

        // R7 no flag in baud mode, R6 reload in baud mode with cap_sel set
        wr16(0, 16'hFFF0);
        wr16(1, 16'hFFF0);
        cap_sel = 1; rx_sel = 1; run_en = 1;
        step(200);
        check(!ovf_flag, "R7", "flag in baud mode", ovf_flag, 0);
        check(cnt_val >= 16'hFFF0, "R6", "baud reload ignores cap_sel", cnt_val, 16'hFFF0);
        run_en = 0; rx_sel = 0; cap_sel = 0;
        step(2);

        // R6 R7 R11 plain auto-reload
        irq_en = 1;
        wr16(1, 16'hFFFA);
        run_en = 1;
        step(10);
        run_en = 0;
        check(ovf_flag, "R7", "flag after overflow", ovf_flag, 1);
        check(irq, "R11", "irq with flag", irq, 1);
        check(cnt_val >= 16'hFFF0 && cnt_val < 16'hFFFA, "R6", "auto-reload value", cnt_val, 16'hFFF0);
        step(5);
        check(ovf_flag, "R11", "flag sticky", ovf_flag, 1);
        clr_ovf_flag = 1; step(1); clr_ovf_flag = 0; step(1);
        check(!ovf_flag && !irq, "R11", "flag cleared", {ovf_flag, irq}, 0);

        // R6 wrap to zero with cap_sel outside baud mode
        cap_sel = 1;
        wr16(0, 16'h8000);
        wr16(1, 16'hFFFA);
        run_en = 1;
        step(10);
        run_en = 0;
        check(cnt_val < 16'h0010, "R6", "wrap to zero", cnt_val, 16'h0004);
        clr_ovf_flag = 1; step(1); clr_ovf_flag = 0; cap_sel = 0;

        // R10 trigger edge in baud mode
        rx_sel = 1; trig_en = 1;
        step(5); ext_trig_pin = 0; step(6);
        check(ext_flag && irq, "R10", "trigger sets flag", {ext_flag, irq}, 2'b11);
        ext_trig_pin = 1;
        clr_ext_flag = 1; step(1); clr_ext_flag = 0; step(1);
        check(!ext_flag, "R11", "ext flag cleared", ext_flag, 0);
        trig_en = 0;
        step(5); ext_trig_pin = 0; step(6);
        check(!ext_flag, "R10", "trigger ignored when disabled", ext_flag, 0);
        ext_trig_pin = 1; irq_en = 0;
        rx_sel = 0;
        step(3);

        // R9 prescaler restarts on re-entry
        wr16(0, 16'hFFFF);
        wr16(1, 16'hFFFF);
        rx_sel = 1; run_en = 1;
        step(20);
        rx_sel = 0; run_en = 0;
        step(3);
        check(!rx_bit_en && !tx_bit_en, "R9", "enables quiet outside baud", {rx_bit_en, tx_bit_en}, 0);
        rx_sel = 1; run_en = 1;
        per = -1;
        for (int t = 1; t < 200; t++) begin
            step(1);
            if (rx_bit_en) begin per = t; break; end
        end
        check(per >= 28 && per <= 38, "R9", "first pulse after re-entry", per, 33);
        run_en = 0; rx_sel = 0;
        step(2);

        finish_run();
    end
endmodule